// File: doc/BRIEF.md
# Latched Status Port with Store-Busy Lockout

This block drives the low nibble of a byte-wide read port that sits beside a slow clock peripheral. It presents four status bits to the bus. Three are level inputs with active-low meaning: the early power-fail warning, the key-switch diagnostic enable and the memory-survival flag. The fourth is a ready flag for a non-volatile EEPROM store. That flag drops on every write strobe to the store and comes back only after a fixed lockout time has run out.

The bus holds its data phase for many cycles, so the four bits must not move while a read is in progress. A strobe at the start of a read loads a snapshot register. The snapshot then holds until a strobe marks the end of the access sequence, and it keeps showing that value between accesses. The three external inputs pass through a synchronizer before they are sampled. Its depth is a parameter, and 0 removes it. The lockout length is a parameter counted in clock cycles. Its default covers 10 ms at a bus clock of about 8.33 MHz.

Top module: `sts_status_port`

## Requirements
- R1: The output field layout is bit 0 = store ready (1 = ready), bit 1 = power-fail level, bit 2 = key-switch level and bit 3 = memory-survival level. The three levels are passed through without inversion and are taken after SYNC_STAGES register stages.
- R2: A write strobe sampled on a clock edge makes the store not ready from that edge onward. A read captured on the next edge returns bit 0 = 0.
- R3: Take a write sampled at edge k with no later write. A read captured at edge k+LOCK_CYCLES still returns bit 0 = 0, and a read captured at edge k+LOCK_CYCLES+1 or later returns bit 0 = 1.
- R4: A write that arrives during the lockout restarts the full lockout from its own edge.
- R5: When the read-start strobe is sampled with no access open, all four bits are captured on that edge and the access is opened.
- R6: While an access is open, the output does not change, whatever the input activity.
- R7: A read-start strobe during an open access is ignored and does not replace the snapshot.
- R8: Once the end strobe closes the access, the output keeps the last snapshot until the next accepted read start.
- R9: After reset the output reads 4'b1111, the store reads ready and no access is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low reset |
| ee_wr_i | input | 1 | One-cycle strobe for a write to the EEPROM store |
| pfail_ni | input | 1 | Power-fail warning, active low |
| key_ni | input | 1 | Key-switch diagnostic enable, active low |
| msurv_ni | input | 1 | Memory-survival flag, active low |
| rd_start_i | input | 1 | Strobe marking the start of a read access |
| rd_end_i | input | 1 | Strobe marking the end of the access sequence |
| stat_o | output | 4 | Latched status nibble for data bits 0 to 3 |

## Verification
Reads are issued under several level combinations of the three external inputs. A bit-order or polarity swap shows up as a mismatch in one nibble position. The ready flag is sampled at the last locked edge and at the first free edge after a write, which separates an off-by-one lockout from a correct one. A second write placed inside a lockout tells a restarting counter from one that ignores the new write. Inputs are also toggled during an open access, and a second start strobe is sent during the access. Both show whether the snapshot really holds or merely follows the live inputs.

// File: rtl/sts_pkg.sv
package sts_pkg;

   localparam int STS_W = 4;

   typedef struct packed {
      logic msurv_n;
      logic key_n;
      logic pfail_n;
      logic ready;
   } sts_word_t;

   localparam sts_word_t STS_RESET = '{msurv_n: 1'b1, key_n: 1'b1,
                                       pfail_n: 1'b1, ready: 1'b1};

   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/sts_sync.sv
module sts_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_r [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_r[i] <= '1;
            end else begin
               stage_r[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_r[i] <= stage_r[i-1];
            end
         end
         assign q = stage_r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sts_lockout.sv
module sts_lockout #(
   parameter int LOCK_CYCLES = 83_333
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   output logic ready
);

   localparam int CW = sts_pkg::cnt_width(LOCK_CYCLES);
   localparam logic [CW-1:0] LOAD = CW'(LOCK_CYCLES);

   logic [CW-1:0] remain_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                remain_r <= '0;
      else if (wr)               remain_r <= LOAD;
      else if (remain_r != '0)   remain_r <= remain_r - 1'b1;
   end

   assign ready = (remain_r == '0);

endmodule

// File: rtl/sts_snap.sv
module sts_snap (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               stop,
   input  sts_pkg::sts_word_t live,
   output sts_pkg::sts_word_t held,
   output logic               open
);

   logic open_r;
   logic take;
   sts_pkg::sts_word_t held_r;

   assign take = start & ~open_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_r <= 1'b0;
         held_r <= sts_pkg::STS_RESET;
      end else begin
         open_r <= (open_r | take) & ~stop;
         if (take) held_r <= live;
      end
   end

   assign held = held_r;
   assign open = open_r;

endmodule

// File: rtl/sts_status_port.sv
module sts_status_port #(
   parameter int LOCK_CYCLES = 83_333,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       ee_wr_i,
   input  logic       pfail_ni,
   input  logic       key_ni,
   input  logic       msurv_ni,
   input  logic       rd_start_i,
   input  logic       rd_end_i,
   output logic [3:0] stat_o
);

   generate
      if (LOCK_CYCLES < 1) begin : g_bad_lock
         $error("LOCK_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (sts_pkg::STS_W != 4) begin : g_bad_w
         $error("status word must be 4 bits");
      end
   endgenerate

   logic [2:0]         lvl_raw;
   logic [2:0]         lvl_syn;
   logic               ready_w;
   logic               in_acc_w;
   sts_pkg::sts_word_t live_w;
   sts_pkg::sts_word_t held_w;

   assign lvl_raw = {msurv_ni, key_ni, pfail_ni};

   sts_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_i),
      .rst_n (rst_ni),
      .d     (lvl_raw),
      .q     (lvl_syn)
   );

   sts_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
      .clk   (clk_i),
      .rst_n (rst_ni),
      .wr    (ee_wr_i),
      .ready (ready_w)
   );

   assign live_w = '{msurv_n: lvl_syn[2], key_n: lvl_syn[1],
                     pfail_n: lvl_syn[0], ready: ready_w};

   sts_snap u_snap (
      .clk   (clk_i),
      .rst_n (rst_ni),
      .start (rd_start_i),
      .stop  (rd_end_i),
      .live  (live_w),
      .held  (held_w),
      .open  (in_acc_w)
   );

   assign stat_o = held_w;

endmodule

// File: rtl/sts_status_chk.sv
module sts_status_chk #(
   parameter int LOCK_CYCLES = 83_333
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       ee_wr_i,
   input logic       rd_start_i,
   input logic [3:0] stat_o,
   input logic       ready_w,
   input logic       in_acc_w
);

   localparam int CW = sts_pkg::cnt_width(LOCK_CYCLES);
   localparam logic [CW-1:0] FULL = CW'(LOCK_CYCLES);

   logic [CW-1:0] since_r;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            since_r <= FULL;
      else if (ee_wr_i)       since_r <= '0;
      else if (since_r != FULL) since_r <= since_r + 1'b1;
   end

   assert_busy_after_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ee_wr_i |=> !ready_w);

   assert_lockout_length_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_w == (since_r == FULL));

   assert_rise_needs_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ready_w) |-> !$past(ee_wr_i));

   assert_capture_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_start_i && !in_acc_w) |=> (stat_o[0] == $past(ready_w)) && in_acc_w);

   assert_hold_in_access_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_acc_w |=> $stable(stat_o));

   assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!in_acc_w && !rd_start_i) |=> $stable(stat_o));

endmodule

bind sts_status_port sts_status_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .ee_wr_i    (ee_wr_i),
   .rd_start_i (rd_start_i),
   .stat_o     (stat_o),
   .ready_w    (ready_w),
   .in_acc_w   (in_acc_w)
);

// File: tb/sts_status_port_tb.sv
module sts_status_port_tb_top;

   localparam int L  = 20;
   localparam int SS = 2;

   typedef struct {
      logic [3:0] v;
      string      tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ee_wr = 1'b0, pfail_n = 1'b1, key_n = 1'b1, msurv_n = 1'b1;
   logic rd_start = 1'b0, rd_end = 1'b0;
   logic [3:0] stat;

   int    n_chk = 0, n_bad = 0;
   longint cyc = 0;
   longint wr_edge = -1000;
   logic [3:0] last_snap = 4'hF;
   item_t q[$];
   event  chk_ev;
   bit    done = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sts_status_port #(.LOCK_CYCLES(L), .SYNC_STAGES(SS)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ee_wr_i(ee_wr), .pfail_ni(pfail_n),
      .key_ni(key_n), .msurv_ni(msurv_n), .rd_start_i(rd_start),
      .rd_end_i(rd_end), .stat_o(stat));

   // monitor: pops expected items and compares with the port
   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (stat !== it.v) begin
               n_bad++;
               $display("FAIL %s: stat=%b expected=%b", it.tag, stat, it.v);
            end
         end
      end
   end

   task automatic push(input logic [3:0] v, input string tag);
      item_t it;
      it.v = v; it.tag = tag;
      q.push_back(it);
      ->chk_ev;
      #0.1;
   endtask

   task automatic set_lvl(input logic p, input logic k, input logic m);
      pfail_n = p; key_n = k; msurv_n = m;
      repeat (SS + 2) @(negedge clk);
   endtask

   task automatic do_write();
      ee_wr = 1'b1;
      wr_edge = cyc + 1;
      @(negedge clk);
      ee_wr = 1'b0;
   endtask

   // starts a read on the next edge; expected value from the model
   task automatic start_read(input string tag, input bit accepted);
      longint cap;
      logic   rdy;
      cap = cyc + 1;
      rdy = ((cap - wr_edge) >= L + 1);
      rd_start = 1'b1;
      @(negedge clk);
      rd_start = 1'b0;
      if (accepted) last_snap = {msurv_n, key_n, pfail_n, rdy};
      push(last_snap, tag);
   endtask

   task automatic end_read();
      rd_end = 1'b1;
      @(negedge clk);
      rd_end = 1'b0;
   endtask

   task automatic wait_to_edge(input longint e);
      while (cyc + 1 < e) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      push(4'hF, "R9 reset value");
      rst_n = 1'b1;
      @(negedge clk);
      push(4'hF, "R9 idle after reset");

      // field layout under several level patterns
      set_lvl(1'b0, 1'b1, 1'b1);
      start_read("R1 R5 pfail low", 1); end_read();
      set_lvl(1'b1, 1'b0, 1'b1);
      start_read("R1 key low", 1); end_read();
      set_lvl(1'b1, 1'b1, 1'b0);
      start_read("R1 msurv low", 1); end_read();
      set_lvl(1'b0, 1'b0, 1'b0);
      start_read("R1 all low", 1); end_read();
      set_lvl(1'b1, 1'b1, 1'b1);

      // write then immediate read
      do_write();
      start_read("R2 busy right after write", 1); end_read();

      // lockout edges
      repeat (L + 5) @(negedge clk);
      do_write();
      wait_to_edge(wr_edge + L);
      start_read("R3 last locked edge", 1); end_read();
      do_write();
      wait_to_edge(wr_edge + L + 1);
      start_read("R3 first free edge", 1); end_read();

      // restart during lockout
      do_write();
      begin
         longint first;
         first = wr_edge;
         repeat (8) @(negedge clk);
         do_write();
         wait_to_edge(first + L + 1);
         start_read("R4 restarted lockout", 1); end_read();
      end
      wait_to_edge(wr_edge + L + 1);
      start_read("R4 free after second write", 1); end_read();

      // hold during an open access
      start_read("R5 open access", 1);
      pfail_n = 1'b0; key_n = 1'b0; msurv_n = 1'b0;
      do_write();
      repeat (SS + 3) @(negedge clk);
      push(last_snap, "R6 inputs moved during access");
      start_read("R7 second start ignored", 0);
      push(last_snap, "R7 snapshot kept");
      end_read();

      // idle hold
      pfail_n = 1'b1; key_n = 1'b0; msurv_n = 1'b1;
      repeat (SS + 3) @(negedge clk);
      push(last_snap, "R8 idle hold");
      start_read("R5 fresh snapshot after end", 1); end_read();

      repeat (2) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule